// File: doc/BRIEF.md
# Flash Double-Word Program and Mass-Erase Sequencer

This block sits between a register bus and a flash array model. Software sets a program-enable bit, then writes two 32-bit words to consecutive addresses. The block pairs them into one 64-bit double word, adds 8 check bits and starts the array programming by itself. No start bit is needed for programming. A whole-array erase is started by setting the mass-erase and start bits together in one control write.

Every fault has its own sticky status flag. Faults covered are a wrong access size, a misaligned pair, rewriting a location that is not erased, a request made while earlier faults are still set, and an erase while write protection is configured. Software clears each flag by writing 1 to it. A second read port lets software, or a bench, inspect any stored 72-bit word.

Array operations are modelled as fixed-latency steps. A program reads the target word first, then waits `PROG_LAT` cycles and writes it. An erase writes one word per cycle across the whole array.

Top module: `nvm_prog_ctrl`

## Requirements
- R1: After reset, busy is 0, every status flag is 0, every control bit is 0 and osc_req is 0.
- R2: Programming needs program-enable set (control bit 0). An accepted word write to an address with bits [2:0] = 0 is held. A word write to that address + 4 then launches programming, and busy is 1 from the next cycle. On success the word at index addr[IDX_W+2:3] becomes {check, second, first}, where check bit i is the XOR of data byte i. The end-of-operation flag (status bit 0) is set and busy clears. Array writes made while program-enable is 0 have no effect.
- R3: An array write with arr_size other than 2 (0 = byte, 1 = half word, 2 = word) sets the size flag (status bit 2) and programs nothing.
- R4: A first word whose address has bits [2:0] not all 0 sets the alignment flag (status bit 3). So does a second word whose address is not the first address + 4. No programming starts in either case.
- R5: If the target data is not all ones (not erased) and the new data is not all zeros, the program error flag (status bit 1) is set, busy clears and the array is unchanged. All-zero data may overwrite a programmed word.
- R6: While any of status bits 5..1 is set, an array write (with program-enable set) or an erase request sets the sequence flag (status bit 4) and is ignored.
- R7: A control write with mass-erase (bit 1) and start (bit 2) both set, while idle, sets every array word to all ones (72 bits). Busy and start stay high until the erase completes. Start then clears itself and the end-of-operation flag is set.
- R8: If wprot_any is 1, an erase request is aborted. The write-protect flag (status bit 5) is set, start stays 0 and busy stays 0.
- R9: osc_req is 1 exactly while the start bit is set and osc_on is 0.
- R10: A control write that clears program-enable discards a held first word.
- R11: Control writes are ignored while busy is high.
- R12: A status write clears each flag whose bit is 1 in sts_wdata. Every other set flag remains set. A flag raised in the same cycle as its clear stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 3 | Control data: [0] program-enable, [1] mass-erase, [2] start |
| sts_we | input | 1 | Status write strobe (write 1 to clear) |
| sts_wdata | input | 6 | Clear mask: [0] end-of-op, [1] program, [2] size, [3] align, [4] sequence, [5] write-protect |
| arr_we | input | 1 | Array write strobe |
| arr_addr | input | ADDR_W | Array byte address |
| arr_size | input | 2 | Access size: 0 byte, 1 half word, 2 word |
| arr_wdata | input | 32 | Array write data |
| wprot_any | input | 1 | A write-protected region is configured |
| osc_on | input | 1 | Oscillator already enabled elsewhere |
| rd_idx | input | IDX_W | Inspection read index |
| rd_word | output | 72 | Stored word at rd_idx, one cycle later |
| ctl_q | output | 3 | Control register contents |
| flags | output | 6 | Status flags, map as in sts_wdata |
| busy | output | 1 | Program or erase in progress |
| osc_req | output | 1 | Oscillator enable request |

## Verification
A fault can be raised in the same cycle that software writes 1 to clear that same flag. The clear must then lose. The bench provokes this by driving a byte-size array write and a status clear of the size flag in one cycle, then checks that the size flag is still set. It also drives a control write while an erase is busy, so that the ignored write coincides with the erase walk. It then confirms that the control bits keep their values and that start drops only when the erase completes.

// File: rtl/nvm_pkg.sv
package nvm_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } acc_size_e;

  localparam int F_EOP   = 0;
  localparam int F_PROG  = 1;
  localparam int F_SIZE  = 2;
  localparam int F_ALIGN = 3;
  localparam int F_SEQ   = 4;
  localparam int F_WPROT = 5;
  localparam int NFLAG   = 6;

  localparam int C_PEN   = 0;
  localparam int C_MER   = 1;
  localparam int C_GO    = 2;

  // one parity bit per data byte
  function automatic logic [7:0] chk_bits(input logic [63:0] d);
    logic [7:0] c;
    for (int i = 0; i < 8; i++) c[i] = ^d[8*i +: 8];
    return c;
  endfunction

endpackage

// File: rtl/nvm_pair_collect.sv
module nvm_pair_collect
  import nvm_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int IDX_W  = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        size,
  input  logic [31:0]       wdata,
  input  logic              flush,
  output logic              launch,
  output logic [IDX_W-1:0]  launch_idx,
  output logic [63:0]       launch_data,
  output logic              err_size,
  output logic              err_align
);

  logic              hold_vld;
  logic [ADDR_W-1:0] hold_addr;
  logic [31:0]       hold_word;
  logic              size_ok;
  logic              first;
  logic              next_ok;
  logic              base_ok;

  always_comb begin
    size_ok     = (size == SZ_WORD);
    first       = !hold_vld;
    base_ok     = (addr[2:0] == 3'b000);
    next_ok     = (addr == hold_addr + ADDR_W'(4));
    err_size    = wr_en && !size_ok;
    err_align   = wr_en && size_ok && (first ? !base_ok : !next_ok);
    launch      = wr_en && size_ok && !first && next_ok;
    launch_idx  = hold_addr[IDX_W+2:3];
    launch_data = {wdata, hold_word};
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      hold_vld  <= 1'b0;
      hold_addr <= '0;
      hold_word <= '0;
    end else if (wr_en) begin
      if (first && size_ok && base_ok) begin
        hold_vld  <= 1'b1;
        hold_addr <= addr;
        hold_word <= wdata;
      end else begin
        hold_vld  <= 1'b0;
      end
    end
  end

  // R4
  hold_align_chk: assert property (@(posedge clk) disable iff (rst)
    hold_vld |-> (hold_addr[2:0] == 3'b000));

endmodule

// File: rtl/nvm_array.sv
module nvm_array #(
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             a_we,
  input  logic [IDX_W-1:0] a_idx,
  input  logic [71:0]      a_wdata,
  output logic [63:0]      a_rdata,
  input  logic [IDX_W-1:0] b_idx,
  output logic [71:0]      b_rdata
);

  localparam int DEPTH = 1 << IDX_W;

  logic [71:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (a_we) mem[a_idx] <= a_wdata;
    a_rdata <= mem[a_idx][63:0];
  end

  always_ff @(posedge clk) begin
    b_rdata <= mem[b_idx];
  end

endmodule

// File: rtl/nvm_engine.sv
module nvm_engine
  import nvm_pkg::*;
#(
  parameter int IDX_W    = 6,
  parameter int PROG_LAT = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_prog,
  input  logic [IDX_W-1:0] prog_idx,
  input  logic [63:0]      prog_data,
  input  logic             start_erase,
  output logic             m_we,
  output logic [IDX_W-1:0] m_idx,
  output logic [71:0]      m_wdata,
  input  logic [63:0]      m_rdata,
  output logic             busy,
  output logic             done_ok,
  output logic             done_perr
);

  localparam int CNT_W = $clog2(PROG_LAT + 1);

  typedef enum logic [2:0] {ST_IDLE, ST_READ, ST_CHECK, ST_PWAIT, ST_ERASE} eng_st_e;

  eng_st_e          st_q;
  logic [IDX_W-1:0] idx_q;
  logic [63:0]      data_q;
  logic [CNT_W-1:0] cnt_q;
  logic             last_idx;
  logic             prog_fire;

  always_comb begin
    last_idx  = (idx_q == {IDX_W{1'b1}});
    prog_fire = (st_q == ST_PWAIT) && (cnt_q == '0);
    done_perr = (st_q == ST_CHECK) && (m_rdata != {64{1'b1}}) && (data_q != 64'd0);
    m_we      = prog_fire || (st_q == ST_ERASE);
    done_ok   = prog_fire || ((st_q == ST_ERASE) && last_idx);
    m_idx     = idx_q;
    m_wdata   = (st_q == ST_ERASE) ? {72{1'b1}} : {chk_bits(data_q), data_q};
    busy      = (st_q != ST_IDLE);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_IDLE;
      idx_q  <= '0;
      data_q <= '0;
      cnt_q  <= '0;
    end else begin
      case (st_q)
        ST_IDLE: begin
          if (start_erase) begin
            st_q  <= ST_ERASE;
            idx_q <= '0;
          end else if (start_prog) begin
            st_q   <= ST_READ;
            idx_q  <= prog_idx;
            data_q <= prog_data;
          end
        end
        ST_READ:  st_q <= ST_CHECK;
        ST_CHECK: begin
          if (done_perr) st_q <= ST_IDLE;
          else begin
            st_q  <= ST_PWAIT;
            cnt_q <= CNT_W'(PROG_LAT - 1);
          end
        end
        ST_PWAIT: begin
          if (cnt_q == '0) st_q <= ST_IDLE;
          else cnt_q <= cnt_q - 1'b1;
        end
        ST_ERASE: begin
          if (last_idx) st_q <= ST_IDLE;
          else idx_q <= idx_q + 1'b1;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // R2
  busy_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(start_prog || start_erase));

  // R5
  perr_stop_chk: assert property (@(posedge clk) disable iff (rst)
    done_perr |=> !busy);

endmodule

// File: rtl/nvm_prog_ctrl.sv
module nvm_prog_ctrl
  import nvm_pkg::*;
#(
  parameter int ADDR_W   = 12,
  parameter int IDX_W    = 6,
  parameter int PROG_LAT = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ctl_we,
  input  logic [2:0]        ctl_wdata,
  input  logic              sts_we,
  input  logic [5:0]        sts_wdata,
  input  logic              arr_we,
  input  logic [ADDR_W-1:0] arr_addr,
  input  logic [1:0]        arr_size,
  input  logic [31:0]       arr_wdata,
  input  logic              wprot_any,
  input  logic              osc_on,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [71:0]       rd_word,
  output logic [2:0]        ctl_q,
  output logic [5:0]        flags,
  output logic              busy,
  output logic              osc_req
);

  logic [2:0]       ctl_r;
  logic [NFLAG-1:0] flg_r;
  logic [NFLAG-1:0] flg_set;
  logic [NFLAG-1:0] flg_clr;
  logic             err_any, ctl_ok, arr_req, arr_seq, col_wr, flush;
  logic             ers_req, ers_seq, ers_wp, ers_go;
  logic             launch, c_err_size, c_err_align;
  logic [IDX_W-1:0] l_idx;
  logic [63:0]      l_data;
  logic             m_we, done_ok, done_perr;
  logic [IDX_W-1:0] m_idx;
  logic [71:0]      m_wdata;
  logic [63:0]      m_rdata;

  always_comb begin
    err_any = |flg_r[NFLAG-1:1];
    ctl_ok  = ctl_we && !busy;
    arr_req = arr_we && ctl_r[C_PEN] && !busy && !ctl_ok;
    arr_seq = arr_req && err_any;
    col_wr  = arr_req && !err_any;
    ers_req = ctl_ok && ctl_wdata[C_MER] && ctl_wdata[C_GO];
    ers_seq = ers_req && err_any;
    ers_wp  = ers_req && !err_any && wprot_any;
    ers_go  = ers_req && !err_any && !wprot_any;
    flush   = (ctl_ok && !ctl_wdata[C_PEN]) || arr_seq;
    flg_set          = '0;
    flg_set[F_EOP]   = done_ok;
    flg_set[F_PROG]  = done_perr;
    flg_set[F_SIZE]  = c_err_size;
    flg_set[F_ALIGN] = c_err_align;
    flg_set[F_SEQ]   = arr_seq || ers_seq;
    flg_set[F_WPROT] = ers_wp;
    flg_clr = sts_we ? sts_wdata : '0;
  end

  nvm_pair_collect #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_pair (
    .clk(clk), .rst(rst), .wr_en(col_wr), .addr(arr_addr), .size(arr_size),
    .wdata(arr_wdata), .flush(flush), .launch(launch), .launch_idx(l_idx),
    .launch_data(l_data), .err_size(c_err_size), .err_align(c_err_align)
  );

  nvm_engine #(.IDX_W(IDX_W), .PROG_LAT(PROG_LAT)) u_eng (
    .clk(clk), .rst(rst), .start_prog(launch), .prog_idx(l_idx),
    .prog_data(l_data), .start_erase(ers_go), .m_we(m_we), .m_idx(m_idx),
    .m_wdata(m_wdata), .m_rdata(m_rdata), .busy(busy), .done_ok(done_ok),
    .done_perr(done_perr)
  );

  nvm_array #(.IDX_W(IDX_W)) u_arr (
    .clk(clk), .a_we(m_we), .a_idx(m_idx), .a_wdata(m_wdata),
    .a_rdata(m_rdata), .b_idx(rd_idx), .b_rdata(rd_word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_r <= '0;
      flg_r <= '0;
    end else begin
      if (ctl_ok) ctl_r <= {ers_go, ctl_wdata[C_MER], ctl_wdata[C_PEN]};
      else if (done_ok) ctl_r[C_GO] <= 1'b0;
      flg_r <= (flg_r & ~flg_clr) | flg_set;
    end
  end

  assign ctl_q   = ctl_r;
  assign flags   = flg_r;
  assign osc_req = ctl_r[C_GO] && !osc_on;

  // R7
  go_busy_chk: assert property (@(posedge clk) disable iff (rst)
    ctl_r[C_GO] |-> busy);

  // R11
  ctl_hold_chk: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(ctl_r[1:0]));

  // R12
  sticky_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((flg_r & $past(flg_r & ~flg_clr)) == $past(flg_r & ~flg_clr)));

  // R8
  wprot_chk: assert property (@(posedge clk) disable iff (rst)
    (ctl_we && !busy && ctl_wdata[C_MER] && ctl_wdata[C_GO] && wprot_any && !err_any)
    |=> (!busy && flg_r[F_WPROT]));

  // R3
  size_chk: assert property (@(posedge clk) disable iff (rst)
    (arr_we && ctl_r[C_PEN] && !busy && !ctl_we && arr_size != SZ_WORD)
    |=> (flg_r[F_SIZE] || flg_r[F_SEQ]));

endmodule

// File: tb/nvm_prog_ctrl_tb_top.sv
module nvm_prog_ctrl_tb_top;

  localparam int ADDR_W = 12;
  localparam int IDX_W  = 6;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              ctl_we = 1'b0;
  logic [2:0]        ctl_wdata = '0;
  logic              sts_we = 1'b0;
  logic [5:0]        sts_wdata = '0;
  logic              arr_we = 1'b0;
  logic [ADDR_W-1:0] arr_addr = '0;
  logic [1:0]        arr_size = '0;
  logic [31:0]       arr_wdata = '0;
  logic              wprot_any = 1'b0;
  logic              osc_on = 1'b0;
  logic [IDX_W-1:0]  rd_idx = '0;
  logic [71:0]       rd_word;
  logic [2:0]        ctl_q;
  logic [5:0]        flags;
  logic              busy;
  logic              osc_req;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  nvm_prog_ctrl #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .PROG_LAT(4)) dut_i (
    .clk(clk), .rst(rst), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .sts_we(sts_we), .sts_wdata(sts_wdata), .arr_we(arr_we),
    .arr_addr(arr_addr), .arr_size(arr_size), .arr_wdata(arr_wdata),
    .wprot_any(wprot_any), .osc_on(osc_on), .rd_idx(rd_idx),
    .rd_word(rd_word), .ctl_q(ctl_q), .flags(flags), .busy(busy),
    .osc_req(osc_req)
  );

  function automatic logic [71:0] pack(input logic [31:0] lo, input logic [31:0] hi);
    logic [63:0] d;
    logic [7:0]  p;
    d = {hi, lo};
    p = '0;
    for (int b = 0; b < 64; b++) p[b/8] = p[b/8] ^ d[b];
    return {p, d};
  endfunction

  task automatic check(input string req, input logic [71:0] act, input logic [71:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // scoreboard
  logic [71:0] exp_q[$];
  string       tag_q[$];
  logic        rd_req = 1'b0;
  logic        rd_pend = 1'b0;

  always @(posedge clk) rd_pend <= rd_req;

  always @(negedge clk) begin
    if (rd_pend && exp_q.size() > 0) check(tag_q.pop_front(), rd_word, exp_q.pop_front());
  end

  task automatic expect_word(input int idx, input logic [71:0] exp, input string req);
    @(negedge clk);
    rd_idx = IDX_W'(idx);
    exp_q.push_back(exp);
    tag_q.push_back(req);
    rd_req = 1'b1;
    @(negedge clk);
    rd_req = 1'b0;
    @(negedge clk);
  endtask

  task automatic ctl_wr(input logic [2:0] v);
    @(negedge clk);
    ctl_we = 1'b1; ctl_wdata = v;
    @(negedge clk);
    ctl_we = 1'b0;
  endtask

  task automatic sts_clr(input logic [5:0] v);
    @(negedge clk);
    sts_we = 1'b1; sts_wdata = v;
    @(negedge clk);
    sts_we = 1'b0;
  endtask

  task automatic arr_wr(input int a, input logic [1:0] sz, input logic [31:0] d);
    @(negedge clk);
    arr_we = 1'b1; arr_addr = ADDR_W'(a); arr_size = sz; arr_wdata = d;
    @(negedge clk);
    arr_we = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 1000 && busy; i++) @(negedge clk);
  endtask

  localparam logic [71:0] ERASED = {72{1'b1}};

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 busy", 72'(busy), 72'd0);
    check("R1 flags", 72'(flags), 72'd0);
    check("R1 ctl", 72'(ctl_q), 72'd0);
    check("R1 osc", 72'(osc_req), 72'd0);

    // R7 erase, R9 oscillator request, R11 ignored control write
    ctl_wr(3'b110);
    check("R7 busy", 72'(busy), 72'd1);
    check("R9 osc_req", 72'(osc_req), 72'd1);
    ctl_wr(3'b000);
    check("R11 ctl kept", 72'(ctl_q), 72'(3'b110));
    wait_idle();
    check("R7 eop", 72'(flags), 72'h01);
    check("R7 start clear", 72'(ctl_q), 72'(3'b010));
    check("R9 osc off", 72'(osc_req), 72'd0);
    expect_word(0, ERASED, "R7 word0");
    expect_word(63, ERASED, "R7 word63");
    sts_clr(6'h01);
    check("R12 clear", 72'(flags), 72'd0);

    // R2 program a pair
    ctl_wr(3'b001);
    arr_wr(8, 2'd2, 32'h1234_5678);
    check("R2 held", 72'(busy), 72'd0);
    arr_wr(12, 2'd2, 32'h9abc_def0);
    check("R2 busy", 72'(busy), 72'd1);
    wait_idle();
    check("R2 eop", 72'(flags), 72'h01);
    expect_word(1, pack(32'h1234_5678, 32'h9abc_def0), "R2 data");
    sts_clr(6'h01);

    // R3 size
    arr_wr(16, 2'd0, 32'hffff_0000);
    check("R3 size", 72'(flags), 72'h04);
    check("R3 busy", 72'(busy), 72'd0);
    expect_word(2, ERASED, "R3 untouched");
    sts_clr(6'h04);

    // R4 alignment
    arr_wr(20, 2'd2, 32'h1);
    check("R4 first", 72'(flags), 72'h08);
    sts_clr(6'h08);
    arr_wr(16, 2'd2, 32'h1);
    arr_wr(24, 2'd2, 32'h2);
    check("R4 second", 72'(flags), 72'h08);
    check("R4 busy", 72'(busy), 72'd0);
    expect_word(2, ERASED, "R4 untouched");
    sts_clr(6'h08);

    // R5 rewrite
    arr_wr(8, 2'd2, 32'h0000_0001);
    arr_wr(12, 2'd2, 32'h0);
    wait_idle();
    check("R5 perr", 72'(flags), 72'h02);
    expect_word(1, pack(32'h1234_5678, 32'h9abc_def0), "R5 unchanged");
    sts_clr(6'h02);
    arr_wr(8, 2'd2, 32'h0);
    arr_wr(12, 2'd2, 32'h0);
    wait_idle();
    check("R5 zeros eop", 72'(flags), 72'h01);
    expect_word(1, 72'd0, "R5 zeros");
    sts_clr(6'h01);

    // R6 sequence
    arr_wr(24, 2'd1, 32'h5);
    arr_wr(24, 2'd2, 32'h5);
    arr_wr(28, 2'd2, 32'h6);
    check("R6 seq", 72'(flags), 72'h14);
    check("R6 busy", 72'(busy), 72'd0);
    expect_word(3, ERASED, "R6 untouched");
    sts_clr(6'h3f);

    // R10 discard held word
    arr_wr(32, 2'd2, 32'h7);
    ctl_wr(3'b000);
    ctl_wr(3'b001);
    arr_wr(36, 2'd2, 32'h8);
    check("R10 discard", 72'(flags), 72'h08);
    check("R10 busy", 72'(busy), 72'd0);
    expect_word(4, ERASED, "R10 untouched");
    sts_clr(6'h08);

    // R12 raise and clear in the same cycle
    @(negedge clk);
    arr_we = 1'b1; arr_addr = ADDR_W'(40); arr_size = 2'd0; arr_wdata = '0;
    sts_we = 1'b1; sts_wdata = 6'h04;
    @(negedge clk);
    arr_we = 1'b0; sts_we = 1'b0;
    check("R12 set wins", 72'(flags), 72'h04);
    sts_clr(6'h04);

    // R2 program-enable off
    ctl_wr(3'b000);
    arr_wr(40, 2'd2, 32'h11);
    arr_wr(44, 2'd2, 32'h22);
    check("R2 pen off busy", 72'(busy), 72'd0);
    check("R2 pen off flags", 72'(flags), 72'd0);
    expect_word(5, ERASED, "R2 pen off");

    // R8 write protect
    wprot_any = 1'b1;
    ctl_wr(3'b110);
    check("R8 busy", 72'(busy), 72'd0);
    check("R8 flag", 72'(flags), 72'h20);
    check("R8 ctl", 72'(ctl_q), 72'(3'b010));
    wprot_any = 1'b0;
    sts_clr(6'h20);

    // R6 erase with pending fault
    ctl_wr(3'b001);
    arr_wr(52, 2'd2, 32'h3);
    ctl_wr(3'b110);
    check("R6 erase seq", 72'(flags), 72'h18);
    check("R6 erase busy", 72'(busy), 72'd0);
    sts_clr(6'h3f);

    // R9 oscillator already on
    osc_on = 1'b1;
    ctl_wr(3'b110);
    check("R9 busy", 72'(busy), 72'd1);
    check("R9 no req", 72'(osc_req), 72'd0);
    wait_idle();
    expect_word(1, ERASED, "R7 reerase");

    repeat (4) @(negedge clk);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule